// File: doc/BRIEF.md
# Overlay Pin Output Controller

This block sits at the pin edge of an on-screen display overlay. It runs on the dot clock and turns per-pixel status flags into pin levels. The flags say whether the pixel is inside a window, on a character or graphics dot, and what its colour is. The block drives three sets of pins: a multiplexed tone/PWM-clock pin, a fast-blanking pin and three colour pins. Every pin has its own output-enable, so a tri-state pad can be placed outside the block.

The multiplexed pin has two uses. It can act as a tone signal, which lowers the gain of the external video amplifiers inside windows so that windows look transparent. It can also act as a square-wave clock for an external PWM unit. In clock mode the divider is restarted on each falling edge of the active-low horizontal sync, so the clock stays locked to the line. A 2-bit mode input selects the half-period length from a four-entry table. The table is written at configuration time, and a new selection takes effect only at the next sync edge.

Top module: `osd_pin_driver`

## Requirements
- R1: After reset, toneOut, toneOe, blankOe and rgbOe are all 0, so the blanking and colour pins are high impedance.
- R2: With pwmClkSel=0, one cycle after the inputs toneOut = dispEn AND winPix AND NOT charPix AND NOT gfxPix.
- R3: With blankCharOnly=0, one cycle after the inputs blankOe = blankOut = dispEn AND (winPix OR charPix). When that value is 0 the blanking pin is released (blankOe=0).
- R4: With blankCharOnly=1, one cycle after the inputs blankOe = blankOut = dispEn AND charPix. gfxPix never affects blanking.
- R5: One cycle after the inputs, rgbOe = dispEn. rgbOut equals rgbIn (bit 2 red, bit 1 green, bit 0 blue) when dispEn=1 and equals 0 when dispEn=0.
- R6: With pwmClkSel=1, a high-to-low transition on hsyncN (driven just after sample n0) restarts the PWM clock. The clock runs with half-period H = halfTab[modeSel] dot clocks. At each later sample n0+j with j>=4, toneOut = ((j-4)/H) mod 2 == 0, so the first phase after sync is high and the duty cycle is 50/50.
- R7: A change of modeSel between sync edges does not alter the running PWM clock. The new half-period applies from the next falling hsync edge.
- R8: A table entry of 0 is treated as a half-period of 1 dot clock.
- R9: toneOe is 1 one cycle after pwmClkSel=1, and equals dispEn one cycle after pwmClkSel=0.
- R10: cfgWrEn=1 writes cfgHalf into table entry cfgAddr on the clock edge. After reset, entry i holds i+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncN | input | 1 | Horizontal sync, active low, asynchronous |
| modeSel | input | 2 | Resolution mode, selects a table entry |
| cfgWrEn | input | 1 | Half-period table write strobe |
| cfgAddr | input | 2 | Table entry to write |
| cfgHalf | input | 8 | Half-period value in dot clocks |
| dispEn | input | 1 | Display enable |
| pwmClkSel | input | 1 | 0: tone on the multiplexed pin, 1: PWM clock |
| blankCharOnly | input | 1 | 0: blank on window or character, 1: character only |
| winPix | input | 1 | Pixel lies inside a window |
| charPix | input | 1 | Character dot is drawn |
| gfxPix | input | 1 | Graphics dot is drawn |
| rgbIn | input | 3 | Pixel colour {R,G,B} |
| toneOut | output | 1 | Multiplexed tone / PWM clock level |
| toneOe | output | 1 | Enable for the multiplexed pin |
| blankOut | output | 1 | Fast-blanking level |
| blankOe | output | 1 | Enable for the fast-blanking pin |
| rgbOut | output | 3 | Colour levels {R,G,B} |
| rgbOe | output | 1 | Enable for the colour pins |

## Verification
The checker tests the combinational pixel rules on every cycle, with their one-cycle latency. It covers the tone value in tone mode, both blanking selections and the colour enable. It also checks the pin enable in clock mode. The phase and period of the PWM clock after a sync edge can only be shown by the bench scenarios. The same holds for a mode change deferred to the next line, for the zero-entry clamp and for table writes. The bench sweeps all four modes and all flag combinations against values it computes itself.

// File: rtl/osd_pin_pkg.sv
package osd_pin_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // sync edge seen: force phase high
    logic toggle;   // half-period complete: invert phase
  } ctlStrobe_t;

  // a zero half-period would never terminate; treat it as one clock
  function automatic logic [7:0] clampHalf(input logic [7:0] h);
    return (h == 8'd0) ? 8'd1 : h;
  endfunction

endpackage

// File: rtl/osd_pin_ctrl.sv
module osd_pin_ctrl
  import osd_pin_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int MODES  = 4,
  localparam int MODE_W = $clog2(MODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgAddr,
  input  logic [HALF_W-1:0] cfgHalf,
  output ctlStrobe_t        strb
);

  logic [2:0]        syncQ;
  logic              syncFall;
  logic [HALF_W-1:0] halfTab [MODES];
  logic [HALF_W-1:0] curLim;
  logic [HALF_W-1:0] cnt;
  logic              atEnd;

  // two synchronizing flops plus one for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[1:0], hsyncN};
  end
  assign syncFall = syncQ[2] & ~syncQ[1];

  // half-period table, one register per mode
  for (genvar i = 0; i < MODES; i++) begin : g_tab
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        halfTab[i] <= HALF_W'(i + 2);
      else if (cfgWrEn && cfgAddr == MODE_W'(i))        halfTab[i] <= cfgHalf;
    end
  end

  // the active limit is picked up only on a sync edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         curLim <= HALF_W'(2);
    else if (syncFall) curLim <= HALF_W'(clampHalf(8'(halfTab[modeSel])));
  end

  assign atEnd = (cnt == curLim - HALF_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (syncFall || atEnd)   cnt <= '0;
    else                          cnt <= cnt + HALF_W'(1);
  end

  always_comb begin
    strb.restart = syncFall;
    strb.toggle  = ~syncFall & atEnd;
  end

endmodule

// File: rtl/osd_pin_dp.sv
module osd_pin_dp
  import osd_pin_pkg::*;
#(
  parameter int COLOR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic               dispEn,
  input  logic               pwmClkSel,
  input  logic               blankCharOnly,
  input  logic               winPix,
  input  logic               charPix,
  input  logic               gfxPix,
  input  logic [COLOR_W-1:0] rgbIn,
  output logic               toneOut,
  output logic               toneOe,
  output logic               blankOut,
  output logic               blankOe,
  output logic [COLOR_W-1:0] rgbOut,
  output logic               rgbOe
);

  logic phase;
  logic toneNext;
  logic blankNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= 1'b1;
    else if (strb.restart)  phase <= 1'b1;
    else if (strb.toggle)   phase <= ~phase;
  end

  always_comb begin
    toneNext  = pwmClkSel ? phase : (dispEn & winPix & ~charPix & ~gfxPix);
    blankNext = dispEn & (blankCharOnly ? charPix : (charPix | winPix));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneOut  <= 1'b0;
      toneOe   <= 1'b0;
      blankOut <= 1'b0;
      blankOe  <= 1'b0;
      rgbOut   <= '0;
      rgbOe    <= 1'b0;
    end else begin
      toneOut  <= toneNext;
      toneOe   <= pwmClkSel | dispEn;
      blankOut <= blankNext;
      blankOe  <= blankNext;
      rgbOut   <= dispEn ? rgbIn : '0;
      rgbOe    <= dispEn;
    end
  end

endmodule

// File: rtl/osd_pin_driver.sv
module osd_pin_driver
  import osd_pin_pkg::*;
#(
  parameter int HALF_W  = 8,
  parameter int MODES   = 4,
  parameter int COLOR_W = 3,
  localparam int MODE_W = $clog2(MODES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncN,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic               cfgWrEn,
  input  logic [MODE_W-1:0]  cfgAddr,
  input  logic [HALF_W-1:0]  cfgHalf,
  input  logic               dispEn,
  input  logic               pwmClkSel,
  input  logic               blankCharOnly,
  input  logic               winPix,
  input  logic               charPix,
  input  logic               gfxPix,
  input  logic [COLOR_W-1:0] rgbIn,
  output logic               toneOut,
  output logic               toneOe,
  output logic               blankOut,
  output logic               blankOe,
  output logic [COLOR_W-1:0] rgbOut,
  output logic               rgbOe
);

  ctlStrobe_t strb;

  osd_pin_ctrl #(.HALF_W(HALF_W), .MODES(MODES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .modeSel(modeSel),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgHalf(cfgHalf), .strb(strb)
  );

  osd_pin_dp #(.COLOR_W(COLOR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dispEn(dispEn),
    .pwmClkSel(pwmClkSel), .blankCharOnly(blankCharOnly),
    .winPix(winPix), .charPix(charPix), .gfxPix(gfxPix), .rgbIn(rgbIn),
    .toneOut(toneOut), .toneOe(toneOe), .blankOut(blankOut),
    .blankOe(blankOe), .rgbOut(rgbOut), .rgbOe(rgbOe)
  );

endmodule

// File: rtl/osd_pin_driver_chk.sv
module osd_pin_driver_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dispEn,
  input logic       pwmClkSel,
  input logic       blankCharOnly,
  input logic       winPix,
  input logic       charPix,
  input logic       gfxPix,
  input logic [2:0] rgbIn,
  input logic       toneOut,
  input logic       toneOe,
  input logic       blankOut,
  input logic       blankOe,
  input logic [2:0] rgbOut,
  input logic       rgbOe
);

  assert_tone_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmClkSel && dispEn && winPix && !charPix && !gfxPix) |=> toneOut);

  assert_tone_dot_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmClkSel && (charPix || gfxPix || !winPix)) |=> !toneOut);

  assert_blank_any_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!blankCharOnly && dispEn && (winPix || charPix)) |=> (blankOe && blankOut));

  assert_blank_char_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (blankCharOnly && !charPix) |=> !blankOe);

  assert_rgb_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dispEn |=> (!rgbOe && rgbOut == 3'b000));

  assert_rgb_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    dispEn |=> (rgbOe && rgbOut == $past(rgbIn)));

  assert_pwm_pin_driven_R9: assert property (@(posedge clk) disable iff (!rstN)
    pwmClkSel |=> toneOe);

endmodule

bind osd_pin_driver osd_pin_driver_chk u_chk (
  .clk(clk), .rstN(rstN), .dispEn(dispEn), .pwmClkSel(pwmClkSel),
  .blankCharOnly(blankCharOnly), .winPix(winPix), .charPix(charPix),
  .gfxPix(gfxPix), .rgbIn(rgbIn), .toneOut(toneOut), .toneOe(toneOe),
  .blankOut(blankOut), .blankOe(blankOe), .rgbOut(rgbOut), .rgbOe(rgbOe)
);

// File: tb/tb_osd_pin_driver.sv
`timescale 1ns/1ps
module tb_osd_pin_driver;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncN = 1'b1;
  logic [1:0] modeSel = '0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgHalf = '0;
  logic       dispEn = 1'b0;
  logic       pwmClkSel = 1'b0;
  logic       blankCharOnly = 1'b0;
  logic       winPix = 1'b0;
  logic       charPix = 1'b0;
  logic       gfxPix = 1'b0;
  logic [2:0] rgbIn = '0;
  logic       toneOut, toneOe, blankOut, blankOe, rgbOe;
  logic [2:0] rgbOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  osd_pin_driver dut (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .modeSel(modeSel),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgHalf(cfgHalf),
    .dispEn(dispEn), .pwmClkSel(pwmClkSel), .blankCharOnly(blankCharOnly),
    .winPix(winPix), .charPix(charPix), .gfxPix(gfxPix), .rgbIn(rgbIn),
    .toneOut(toneOut), .toneOe(toneOe), .blankOut(blankOut),
    .blankOe(blankOe), .rgbOut(rgbOut), .rgbOe(rgbOe)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeTab(input int addr, input int val);
    cfgAddr = 2'(addr); cfgHalf = 8'(val); cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // drive a sync pulse just after a sample and check the clock pattern
  // for nPer half-periods of length h; optionally switch mode midway
  task automatic runLine(input string req, input int h, input int nPer,
                         input bit swapMode, input logic [1:0] newMode);
    hsyncN = 1'b0;
    for (int j = 1; j <= 4 + nPer * h; j++) begin
      @(negedge clk);
      if (j == 3) hsyncN = 1'b1;
      if (swapMode && j == 5) modeSel = newMode;
      if (j >= 4) check(req, int'(toneOut), (((j - 4) / h) % 2 == 0) ? 1 : 0);
    end
  endtask

  int tabVal [4] = '{3, 5, 2, 4};

  initial begin
    @(negedge clk);
    // R1: reset state
    check("R1 toneOut", int'(toneOut), 0);
    check("R1 toneOe",  int'(toneOe), 0);
    check("R1 blankOe", int'(blankOe), 0);
    check("R1 rgbOe",   int'(rgbOe), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 toneOe off", int'(toneOe), 0);

    // R2..R5 sweep of every flag combination
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 8; f++) begin
          dispEn = d[0]; blankCharOnly = s[0];
          winPix = f[2]; charPix = f[1]; gfxPix = f[0];
          rgbIn = 3'(f ^ 5);
          @(negedge clk);
          check("R2 tone", int'(toneOut),
                (d == 1 && f[2] && !f[1] && !f[0]) ? 1 : 0);
          if (s == 0) begin
            check("R3 blankOe", int'(blankOe), (d == 1 && (f[2] || f[1])) ? 1 : 0);
            check("R3 blankOut", int'(blankOut), (d == 1 && (f[2] || f[1])) ? 1 : 0);
          end else begin
            check("R4 blankOe", int'(blankOe), (d == 1 && f[1]) ? 1 : 0);
            check("R4 blankOut", int'(blankOut), (d == 1 && f[1]) ? 1 : 0);
          end
          check("R5 rgbOe", int'(rgbOe), d);
          check("R5 rgbOut", int'(rgbOut), (d == 1) ? ((f ^ 5) & 7) : 0);
          check("R9 toneOe tone", int'(toneOe), d);
        end
      end
    end

    // R10, R6: load table, then every mode
    dispEn = 1'b0; winPix = 1'b0; charPix = 1'b0; gfxPix = 1'b0;
    for (int m = 0; m < 4; m++) writeTab(m, tabVal[m]);
    pwmClkSel = 1'b1;
    @(negedge clk);
    check("R9 toneOe pwm", int'(toneOe), 1);
    for (int m = 0; m < 4; m++) begin
      modeSel = 2'(m);
      runLine("R6 R10 pwm phase", tabVal[m], 4, 1'b0, 2'd0);
    end

    // R7: mode change mid-line is deferred
    modeSel = 2'd0;
    runLine("R7 old period kept", tabVal[0], 4, 1'b1, 2'd1);
    runLine("R7 new period", tabVal[1], 4, 1'b0, 2'd0);

    // R8: zero entry clamps to one
    writeTab(2, 0);
    modeSel = 2'd2;
    runLine("R8 zero half", 1, 8, 1'b0, 2'd0);

    // R10: reset defaults i+2 after a fresh reset
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      modeSel = 2'(m);
      runLine("R10 default table", m + 2, 3, 1'b0, 2'd0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule